// File: doc/BRIEF.md
# Four-Wire Host Command Serial Port

This block is the slave side of a four-wire serial link through which a host microcontroller commands a recorder controller. The host pulls an active-low select wire, clocks bits in on a serial data-in wire with a bit clock, and receives read data on a serial data-out wire. Every transfer opens with a 4-bit opcode, sent MSB first. A write opcode chooses how long the payload is: an 8-bit control word, a 10-bit start address for the address counter, or a 16-bit end address. When the payload is complete, the block issues a one-cycle parallel strobe carrying the value. A read opcode chooses the status register, the extended address counter or the regular address counter. The value goes out MSB first on the data-out wire.

All four wires are asynchronous to the block clock. They are brought in through flop synchronizers, and the bit-clock edges are detected in the clock domain. Data-in is sampled on bit-clock falling edges. Read bits advance on bit-clock rising edges. The rising edge that closes the opcode's last clock pulse is skipped, so the first read bit is already present before the host's next falling edge. An enable input lets the surrounding mode logic lock the port out.

The controller is a state machine with five states:
- S_IDLE: select is high.
- S_CMD: the opcode is being shifted in.
- S_WDATA: the write payload is being shifted in.
- S_RDATA: the read value is being shifted out.
- S_DONE: the transfer has finished or was ignored, and the block waits for select to rise.

Its transitions are:
- IDLE→CMD when select is low and enable is high.
- CMD→WDATA on a write opcode.
- CMD→RDATA on a read opcode.
- CMD→DONE on an unknown opcode.
- WDATA→DONE on the last payload bit.
- RDATA→DONE when the last read bit has been shifted out.
- Any state→IDLE when select goes high or enable goes low.

Top module: `mcuport`

## Requirements
- R1: After reset, sdo is 0 and ctrl_we, start_ld and end_we are all 0.
- R2: sdi is sampled on falling edges of sclk, MSB first. The first 4 bits of each transfer form the opcode.
- R3: Opcode 4'b0001 followed by 8 bits produces one single-cycle ctrl_we pulse, with ctrl_word equal to those bits.
- R4: Opcode 4'b0010 followed by 10 bits produces one single-cycle start_ld pulse, with start_addr equal to those bits.
- R5: Opcode 4'b0011 followed by 16 bits produces one single-cycle end_we pulse, with end_addr equal to those bits.
- R6: On a read opcode, the MSB of the selected value is on sdo before the next sclk falling edge. Each further sclk rising edge advances one bit. The read opcodes are:
  - 4'b1001: status_in, 8 bits.
  - 4'b1010: ext_addr_in, zero-extended to 8 bits.
  - 4'b1011: addr_cnt_in, 16 bits.
- R7: sdo is 0 whenever no read is shifting out, including after the last read bit.
- R8: Select going high at any point aborts the transfer with no strobe, and the next transfer starts from a fresh opcode.
- R9: Any other opcode is ignored: no strobe is produced and sdo stays 0.
- R10: While en is 0, no transfer is accepted and no strobe is produced.
- R11: At most one strobe fires per transfer. Extra sclk pulses after the payload have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable from mode logic |
| sel_n | input | 1 | Active-low select from host |
| sdi | input | 1 | Serial data in |
| sclk | input | 1 | Host bit clock, idle high |
| sdo | output | 1 | Serial data out |
| status_in | input | STAT_W | Status register value for reads |
| ext_addr_in | input | EXT_W | Extended address counter value |
| addr_cnt_in | input | CNT_W | Regular address counter value |
| ctrl_we | output | 1 | Control word strobe |
| ctrl_word | output | CTRL_W | Control word |
| start_ld | output | 1 | Start address load strobe |
| start_addr | output | START_W | Start address |
| end_we | output | 1 | End address strobe |
| end_addr | output | END_W | End address |

## Verification
The bench builds the block with its default parameters:
- The 8-, 10- and 16-bit payload widths make all three write lengths appear on one port.
- The 6-bit extended counter puts the zero-extension path of reads within reach.
- The two-stage synchronizers set the edge latency.

The host model's half bit period is six clock cycles. That is long enough for the skipped first rising edge and for each read shift to settle before the host samples on the following falling edge.

// File: rtl/mcuport_pkg.sv
package mcuport_pkg;

    localparam int CMD_W = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_WDATA,
        S_RDATA,
        S_DONE
    } port_state_t;

    typedef enum logic [1:0] {
        K_NONE,
        K_WRITE,
        K_READ
    } op_kind_t;

    localparam logic [CMD_W-1:0] OP_WCTRL  = 4'b0001;
    localparam logic [CMD_W-1:0] OP_WSTART = 4'b0010;
    localparam logic [CMD_W-1:0] OP_WEND   = 4'b0011;
    localparam logic [CMD_W-1:0] OP_RSTAT  = 4'b1001;
    localparam logic [CMD_W-1:0] OP_REXT   = 4'b1010;
    localparam logic [CMD_W-1:0] OP_RCNT   = 4'b1011;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int byte_round(input int w);
        return ((w + 7) / 8) * 8;
    endfunction

    function automatic op_kind_t op_kind(input logic [CMD_W-1:0] op);
        op_kind_t k;
        unique case (op)
            OP_WCTRL, OP_WSTART, OP_WEND: k = K_WRITE;
            OP_RSTAT, OP_REXT, OP_RCNT:   k = K_READ;
            default:                      k = K_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/mcuport_sync.sv
module mcuport_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff[0] <= RESET_VAL;
        else        ff[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff[i] <= RESET_VAL;
            else        ff[i] <= ff[i-1];
        end
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/mcuport_rx.sv
module mcuport_rx #(
    parameter int W  = 16,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          shift,
    input  logic          din,
    output logic [W-1:0]  peek,
    output logic [CW-1:0] count
);
    logic [W-2:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg  <= '0;
            count <= '0;
        end else if (clear) begin
            sreg  <= '0;
            count <= '0;
        end else if (shift) begin
            sreg  <= peek[W-2:0];
            count <= count + 1'b1;
        end
    end

    assign peek = {sreg, din};

    // R2
    rx_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !clear) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/mcuport_tx.sv
module mcuport_tx #(
    parameter int W  = 16,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [W-1:0]  load_val,
    input  logic [CW-1:0] load_len,
    input  logic          shift,
    output logic          dout,
    output logic [CW-1:0] remaining
);
    logic [W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg      <= '0;
            remaining <= '0;
        end else if (clear) begin
            sreg      <= '0;
            remaining <= '0;
        end else if (load) begin
            sreg      <= load_val;
            remaining <= load_len;
        end else if (shift && remaining != '0) begin
            sreg      <= {sreg[W-2:0], 1'b0};
            remaining <= remaining - 1'b1;
        end
    end

    assign dout = (remaining != '0) ? sreg[W-1] : 1'b0;

    // R6
    tx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load && !clear && remaining != '0) |=> (remaining == $past(remaining) - 1'b1));

    // R7
    tx_empty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (remaining == '0) |-> !dout);
endmodule

// File: rtl/mcuport.sv
module mcuport
    import mcuport_pkg::*;
#(
    parameter int CTRL_W      = 8,
    parameter int START_W     = 10,
    parameter int END_W       = 16,
    parameter int STAT_W      = 8,
    parameter int EXT_W       = 6,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               sel_n,
    input  logic               sdi,
    input  logic               sclk,
    output logic               sdo,
    input  logic [STAT_W-1:0]  status_in,
    input  logic [EXT_W-1:0]   ext_addr_in,
    input  logic [CNT_W-1:0]   addr_cnt_in,
    output logic               ctrl_we,
    output logic [CTRL_W-1:0]  ctrl_word,
    output logic               start_ld,
    output logic [START_W-1:0] start_addr,
    output logic               end_we,
    output logic [END_W-1:0]   end_addr
);
    localparam int SH_W     = imax(imax(imax(CTRL_W, START_W), END_W), CMD_W);
    localparam int STAT_LEN = byte_round(STAT_W);
    localparam int EXT_LEN  = byte_round(EXT_W);
    localparam int CNT_LEN  = byte_round(CNT_W);
    localparam int RD_W     = imax(imax(STAT_LEN, EXT_LEN), CNT_LEN);
    localparam int LEN_W    = $clog2(imax(SH_W, RD_W) + 1);

    // ---------------- synchronizers and edge detection ----------------
    logic sclk_s, sel_s, sdi_s, sclk_d;
    logic sclk_fall, sclk_rise;

    mcuport_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
    mcuport_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_sel (
        .clk(clk), .rst_n(rst_n), .d(sel_n), .q(sel_s));
    mcuport_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b1;
        else        sclk_d <= sclk_s;
    end

    assign sclk_fall = sclk_d && !sclk_s;
    assign sclk_rise = !sclk_d && sclk_s;

    // ---------------- state and datapath signals ----------------
    port_state_t          state, nxt;
    logic [CMD_W-1:0]     op_q;
    logic                 skip_q;
    logic                 abort;
    logic [SH_W-1:0]      rx_peek;
    logic [LEN_W-1:0]     rx_count;
    logic                 rx_clear, rx_shift;
    logic [CMD_W-1:0]     op_now;
    op_kind_t             kind_now;
    logic                 cmd_last, cmd_done;
    logic [LEN_W-1:0]     pay_len;
    logic                 pay_last;
    logic                 tx_load, tx_shift, tx_clear;
    logic [RD_W-1:0]      rd_val;
    logic [LEN_W-1:0]     rd_len;
    logic [LEN_W-1:0]     tx_rem;
    logic                 write_fire;

    assign abort    = sel_s || !en;
    assign op_now   = CMD_W'(rx_peek);
    assign kind_now = op_kind(op_now);
    assign cmd_last = (rx_count == LEN_W'(CMD_W - 1));
    assign cmd_done = (state == S_CMD) && sclk_fall && cmd_last && !abort;

    always_comb begin
        unique case (op_q)
            OP_WCTRL:  pay_len = LEN_W'(CTRL_W);
            OP_WSTART: pay_len = LEN_W'(START_W);
            OP_WEND:   pay_len = LEN_W'(END_W);
            default:   pay_len = LEN_W'(1);
        endcase
    end

    assign pay_last   = (rx_count == pay_len - 1'b1);
    assign write_fire = (state == S_WDATA) && sclk_fall && pay_last && !abort;

    // ---------------- read value selection ----------------
    always_comb begin
        rd_val = '0;
        rd_len = '0;
        unique case (op_now)
            OP_RSTAT: begin
                rd_val = RD_W'(status_in) << (RD_W - STAT_LEN);
                rd_len = LEN_W'(STAT_LEN);
            end
            OP_REXT: begin
                rd_val = RD_W'(ext_addr_in) << (RD_W - EXT_LEN);
                rd_len = LEN_W'(EXT_LEN);
            end
            OP_RCNT: begin
                rd_val = RD_W'(addr_cnt_in) << (RD_W - CNT_LEN);
                rd_len = LEN_W'(CNT_LEN);
            end
            default: begin
                rd_val = '0;
                rd_len = '0;
            end
        endcase
    end

    assign rx_clear = (state == S_IDLE) || (state == S_DONE) || cmd_done || abort;
    assign rx_shift = sclk_fall && ((state == S_CMD) || (state == S_WDATA));
    assign tx_load  = cmd_done && (kind_now == K_READ);
    assign tx_clear = (state != S_RDATA && !tx_load) || abort;
    assign tx_shift = (state == S_RDATA) && sclk_rise && !skip_q;

    mcuport_rx #(.W(SH_W), .CW(LEN_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clear(rx_clear), .shift(rx_shift),
        .din(sdi_s), .peek(rx_peek), .count(rx_count));

    mcuport_tx #(.W(RD_W), .CW(LEN_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .clear(tx_clear), .load(tx_load),
        .load_val(rd_val), .load_len(rd_len), .shift(tx_shift),
        .dout(sdo), .remaining(tx_rem));

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            op_q   <= '0;
            skip_q <= 1'b0;
        end else begin
            state <= nxt;
            if (cmd_done) op_q <= op_now;
            if (tx_load)
                skip_q <= 1'b1;
            else if (state == S_RDATA && sclk_rise)
                skip_q <= 1'b0;
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (!sel_s && en) nxt = S_CMD;
            S_CMD: begin
                if (sclk_fall && cmd_last) begin
                    unique case (kind_now)
                        K_WRITE: nxt = S_WDATA;
                        K_READ:  nxt = S_RDATA;
                        default: nxt = S_DONE;
                    endcase
                end
            end
            S_WDATA: if (sclk_fall && pay_last) nxt = S_DONE;
            S_RDATA: if (!skip_q && tx_rem == '0) nxt = S_DONE;
            S_DONE:  nxt = S_DONE;
            default: nxt = S_IDLE;
        endcase
        if (abort) nxt = S_IDLE;
    end

    // ---------------- output process ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_we    <= 1'b0;
            start_ld   <= 1'b0;
            end_we     <= 1'b0;
            ctrl_word  <= '0;
            start_addr <= '0;
            end_addr   <= '0;
        end else begin
            ctrl_we  <= 1'b0;
            start_ld <= 1'b0;
            end_we   <= 1'b0;
            if (write_fire) begin
                unique case (op_q)
                    OP_WCTRL: begin
                        ctrl_we   <= 1'b1;
                        ctrl_word <= CTRL_W'(rx_peek);
                    end
                    OP_WSTART: begin
                        start_ld   <= 1'b1;
                        start_addr <= START_W'(rx_peek);
                    end
                    OP_WEND: begin
                        end_we   <= 1'b1;
                        end_addr <= END_W'(rx_peek);
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- assertions ----------------
    // R11
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_we, start_ld, end_we}));

    // R3
    ctrl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> !ctrl_we);

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ld |=> !start_ld);

    // R5
    end_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_we |-> ($past(state) == S_WDATA));

    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> (state == S_IDLE));

    // R10
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == S_IDLE && !ctrl_we && !start_ld && !end_we));

    // R7
    sdo_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_RDATA) |-> !sdo);
endmodule

// File: tb/mcuport_tb.sv
module mcuport_tb;
    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic        sel_n = 1'b1;
    logic        sdi = 1'b0;
    logic        sclk = 1'b1;
    logic        sdo;
    logic [7:0]  status_in = 8'hA5;
    logic [5:0]  ext_addr_in = 6'h2B;
    logic [15:0] addr_cnt_in = 16'hC35E;
    logic        ctrl_we, start_ld, end_we;
    logic [7:0]  ctrl_word;
    logic [9:0]  start_addr;
    logic [15:0] end_addr;

    always #4 clk = ~clk;

    mcuport u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .sel_n(sel_n), .sdi(sdi),
        .sclk(sclk), .sdo(sdo), .status_in(status_in),
        .ext_addr_in(ext_addr_in), .addr_cnt_in(addr_cnt_in),
        .ctrl_we(ctrl_we), .ctrl_word(ctrl_word), .start_ld(start_ld),
        .start_addr(start_addr), .end_we(end_we), .end_addr(end_addr));

    int n_checks = 0;
    int n_fail = 0;
    int n_ctrl = 0, n_start = 0, n_end = 0;
    logic [7:0]  last_ctrl = '0;
    logic [9:0]  last_start = '0;
    logic [15:0] last_end = '0;
    bit done = 1'b0;

    always @(posedge clk) begin
        if (ctrl_we)  begin n_ctrl++;  last_ctrl  <= ctrl_word;  end
        if (start_ld) begin n_start++; last_start <= start_addr; end
        if (end_we)   begin n_end++;   last_end   <= end_addr;   end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic host_sel();
        sel_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic host_desel();
        repeat (H) @(negedge clk);
        sel_n = 1'b1;
        repeat (2 * H) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sdi = b;
        repeat (H) @(negedge clk);
        s = sdo;
        sclk = 1'b0;
        repeat (H) @(negedge clk);
        sclk = 1'b1;
    endtask

    task automatic send_op(input logic [3:0] op);
        logic s;
        for (int i = 3; i >= 0; i--) clk_bit(op[i], s);
    endtask

    task automatic run_bits(input logic [15:0] d, input int nb, output logic [15:0] rd);
        logic s;
        rd = '0;
        for (int i = nb - 1; i >= 0; i--) begin
            clk_bit(d[i], s);
            rd = {rd[14:0], s};
        end
    endtask

    // {opcode[3:0], data[15:0], nbits[4:0]}
    localparam logic [24:0] VEC [10] = '{
        {4'b0001, 16'h005A, 5'd8},
        {4'b0010, 16'h02C7, 5'd10},
        {4'b0011, 16'hBEEF, 5'd16},
        {4'b1001, 16'h0000, 5'd8},
        {4'b1010, 16'h0000, 5'd8},
        {4'b1011, 16'h0000, 5'd16},
        {4'b0111, 16'hFFFF, 5'd8},
        {4'b0001, 16'h0081, 5'd8},
        {4'b1100, 16'hFFFF, 5'd16},
        {4'b0011, 16'h1234, 5'd16}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        int c0, s0, e0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 sdo", {31'b0, sdo}, 0);
        chk("R1 strobes", {29'b0, ctrl_we, start_ld, end_we}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 sdo after release", {31'b0, sdo}, 0);

        // Table-driven main walk
        for (int v = 0; v < 10; v++) begin
            logic [3:0]  op;
            logic [15:0] dat;
            int          nb;
            op  = VEC[v][24:21];
            dat = VEC[v][20:5];
            nb  = int'(VEC[v][4:0]);
            c0 = n_ctrl; s0 = n_start; e0 = n_end;
            host_sel();
            send_op(op);
            run_bits(dat, nb, rd);
            host_desel();
            case (op)
                4'b0001: begin
                    chk("R3 ctrl count", n_ctrl - c0, 1);
                    chk("R3 R2 ctrl value", {24'b0, last_ctrl}, {24'b0, dat[7:0]});
                end
                4'b0010: begin
                    chk("R4 start count", n_start - s0, 1);
                    chk("R4 R2 start value", {22'b0, last_start}, {22'b0, dat[9:0]});
                end
                4'b0011: begin
                    chk("R5 end count", n_end - e0, 1);
                    chk("R5 R2 end value", {16'b0, last_end}, {16'b0, dat});
                end
                4'b1001: chk("R6 status read", {24'b0, rd[7:0]}, 32'hA5);
                4'b1010: chk("R6 ext read zero-extended", {24'b0, rd[7:0]}, 32'h2B);
                4'b1011: chk("R6 counter read", {16'b0, rd}, 32'hC35E);
                default: begin
                    chk("R9 no strobe", (n_ctrl - c0) + (n_start - s0) + (n_end - e0), 0);
                    chk("R9 sdo low", {16'b0, rd}, 0);
                end
            endcase
        end

        // R8: abort mid-payload, then a fresh transfer
        c0 = n_ctrl;
        host_sel();
        send_op(4'b0001);
        run_bits(16'h000F, 4, rd);
        host_desel();
        chk("R8 no strobe on abort", n_ctrl - c0, 0);
        host_sel();
        send_op(4'b0001);
        run_bits(16'h003C, 8, rd);
        host_desel();
        chk("R8 fresh transfer count", n_ctrl - c0, 1);
        chk("R8 fresh transfer value", {24'b0, last_ctrl}, 32'h3C);

        // R10: disabled port
        en = 1'b0;
        c0 = n_ctrl;
        host_sel();
        send_op(4'b0001);
        run_bits(16'h00FF, 8, rd);
        host_desel();
        chk("R10 no strobe when disabled", n_ctrl - c0, 0);
        chk("R10 value kept", {24'b0, ctrl_word}, 32'h3C);
        en = 1'b1;
        repeat (4) @(negedge clk);

        // R11: extra pulses after payload
        s0 = n_start;
        host_sel();
        send_op(4'b0010);
        run_bits(16'h0155, 10, rd);
        run_bits(16'hFFFF, 8, rd);
        host_desel();
        chk("R11 single strobe", n_start - s0, 1);
        chk("R11 value unchanged", {22'b0, last_start}, 32'h155);

        // R7: sdo low after last read bit and while idle
        host_sel();
        send_op(4'b1001);
        run_bits(16'h0000, 8, rd);
        chk("R6 status read again", {24'b0, rd[7:0]}, 32'hA5);
        run_bits(16'h0000, 8, rd);
        chk("R7 sdo low after read", {16'b0, rd}, 0);
        host_desel();
        chk("R7 sdo low idle", {31'b0, sdo}, 0);

        finish_run();
    end
endmodule